// File: doc/BRIEF.md
# CRC-Gated Receive Staging Buffer

This block takes a byte stream of incoming serial-bus transactions. Each transaction is one command byte, then header bytes, then optional write data. The bytes are held in a staging store until the transaction is complete. One cycle after the final byte is accepted, the block samples an externally computed CRC-error flag:

- If the flag is set, the staged bytes are thrown away in a single cycle by moving the staging write pointer back to the read pointer.
- If the flag is clear, the bytes are copied one per cycle into one of two byte-wide downstream queues. The tag that came with the final byte selects either the posted queue or the non-posted queue.

Each downstream queue is a first-word-fall-through FIFO that a consumer drains byte by byte, one transaction at a time. Each queue also reports a free flag. The flag stays high only while the queue can still absorb a worst-case transaction of its class:

- Posted queue: the maximum posted payload plus one full header plus the command byte.
- Non-posted queue: one full header plus the command byte.

Upstream framing is carried by a start pulse that accompanies the first byte and an end pulse that accompanies the last byte. Input is held off through the check cycle and the copy phase, so the staging store only ever holds one transaction. The staging depth must be a power of two and at least the longest transaction.

Top module: `crc_stage_buf`

## Requirements
- R1: After reset, in_ready_o is 1, pc_empty_o and np_empty_o are 1, and pc_free_o and np_free_o are 1.
- R2: A transaction whose end byte carries in_posted_i=1 and whose crc_err_i is 0 in the check cycle appears in the posted queue. Its bytes are in arrival order, and the non-posted queue stays empty.
- R3: A transaction tagged in_posted_i=0 with crc_err_i=0 appears in the non-posted queue in arrival order, and the posted queue is not touched.
- R4: If crc_err_i is 1 in the cycle after the end byte is accepted, no byte of that transaction reaches either queue. The next transaction is delivered intact.
- R5: The end byte is accepted at edge k. in_ready_o is 0 after edge k. The target queue is still empty after edge k+1. The first byte is visible on the queue output after edge k+2. in_ready_o stays 0 until the last byte has been copied.
- R6: While the target queue is full, the copy stalls with no byte lost or duplicated, and in_ready_o stays 0. The copy resumes as the consumer pops.
- R7: pc_free_o is 1 exactly when the free space in the posted queue is at least MAX_PAYLOAD+HDR_BYTES+1. With the defaults this is 13 of 32 entries.
- R8: np_free_o is 1 exactly when the free space in the non-posted queue is at least HDR_BYTES+1. With the defaults this is 5 of 16 entries.
- R9: Bytes accepted while no transaction is open (no start pulse seen since the last end byte) are discarded.
- R10: A start pulse that arrives while a transaction is open discards the partial bytes and begins a new transaction with that byte.
- R11: A one-byte transaction, with the start and end pulses on the same byte, is delivered like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_sot_i | input | 1 | Marks the first byte of a transaction |
| in_eot_i | input | 1 | Marks the last byte of a transaction |
| in_posted_i | input | 1 | Class tag, sampled with the last byte: 1 posted, 0 non-posted |
| crc_err_i | input | 1 | CRC error flag, sampled in the cycle after the last byte |
| in_ready_o | output | 1 | Input byte is accepted when valid and ready |
| pc_pop_i | input | 1 | Pop the posted queue (ignored when empty) |
| pc_data_o | output | 8 | Head byte of the posted queue |
| pc_empty_o | output | 1 | Posted queue empty |
| pc_free_o | output | 1 | Posted queue can take a worst-case posted transaction |
| np_pop_i | input | 1 | Pop the non-posted queue (ignored when empty) |
| np_data_o | output | 8 | Head byte of the non-posted queue |
| np_empty_o | output | 1 | Non-posted queue empty |
| np_free_o | output | 1 | Non-posted queue can take a worst-case non-posted transaction |

## Verification
The bench drives inputs on the falling edge. Each byte it drives is therefore accepted at the next rising edge, and every output is read one half period after the edge that set it.

The latency check follows the R5 schedule exactly:

- in_ready_o low right after the end byte.
- Queue still empty one edge later, while the CRC is sampled.
- First byte on the queue output at the second edge.

Free flags and queue contents are checked only after in_ready_o has returned high, once the copy has finished. The one exception is the stall scenario, which is checked while the target is full and again as pops make room.

// File: rtl/crc_stage_pkg.sv
package crc_stage_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_CHECK   = 2'd1,
    ST_DRAIN   = 2'd2
  } stage_state_e;
endpackage

// File: rtl/stage_buf.sv
// Staging store with single-cycle rewind of the write pointer to the read pointer.
module stage_buf #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rewind_i,
  input  logic          rd_en_i,
  output logic [7:0]    rd_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] wr_q, rd_q;
  logic [AW-1:0] wr_addr;

  // a write that coincides with a rewind lands at the read pointer
  assign wr_addr = rewind_i ? rd_q[AW-1:0] : wr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (rewind_i)     wr_q <= rd_q + CW'(wr_en_i);
      else if (wr_en_i) wr_q <= wr_q + 1'b1;
      if (rd_en_i)      rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_q[AW-1:0]];
  assign count_o   = wr_q - rd_q;
  assign empty_o   = (count_o == '0);
  assign full_o    = (count_o == CW'(DEPTH));

  a_r11_stage_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  a_r4_rewind_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewind_i && !wr_en_i && !rd_en_i) |=> empty_o);
endmodule

// File: rtl/byte_fifo.sv
// First-word-fall-through byte queue; pops on empty are ignored.
module byte_fifo #(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    data_i,
  input  logic          pop_i,
  output logic [7:0]    data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [LW-1:0] wr_q, rd_q;
  logic          pop_ok;

  assign pop_ok = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_ok) rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  assign data_o  = mem_q[rd_q[AW-1:0]];
  assign level_o = wr_q - rd_q;
  assign empty_o = (level_o == '0);
  assign full_o  = (level_o == LW'(DEPTH));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/crc_stage_buf.sv
module crc_stage_buf
  import crc_stage_pkg::*;
#(
  parameter int STAGE_DEPTH = 16,
  parameter int PC_DEPTH    = 32,
  parameter int NP_DEPTH    = 16,
  parameter int HDR_BYTES   = 4,
  parameter int MAX_PAYLOAD = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_sot_i,
  input  logic       in_eot_i,
  input  logic       in_posted_i,
  input  logic       crc_err_i,
  output logic       in_ready_o,
  input  logic       pc_pop_i,
  output logic [7:0] pc_data_o,
  output logic       pc_empty_o,
  output logic       pc_free_o,
  input  logic       np_pop_i,
  output logic [7:0] np_data_o,
  output logic       np_empty_o,
  output logic       np_free_o
);
  localparam int SCW     = $clog2(STAGE_DEPTH) + 1;
  localparam int PLW     = $clog2(PC_DEPTH) + 1;
  localparam int NLW     = $clog2(NP_DEPTH) + 1;
  localparam int PC_NEED = MAX_PAYLOAD + HDR_BYTES + 1;
  localparam int NP_NEED = HDR_BYTES + 1;

  stage_state_e   state_q;
  logic           active_q, posted_q;
  logic           accept, st_wr, st_rewind, st_rd;
  logic           st_empty, st_full;
  logic [7:0]     st_data;
  logic [SCW-1:0] st_count;
  logic           pc_push, np_push, pc_full, np_full, tgt_full, move;
  logic [PLW-1:0] pc_level;
  logic [NLW-1:0] np_level;

  assign in_ready_o = (state_q == ST_COLLECT) && !st_full;
  assign accept     = in_valid_i && in_ready_o;
  assign st_wr      = accept && (in_sot_i || active_q);
  assign st_rewind  = (accept && in_sot_i) || ((state_q == ST_CHECK) && crc_err_i);
  assign tgt_full   = posted_q ? pc_full : np_full;
  assign move       = (state_q == ST_DRAIN) && !st_empty && !tgt_full;
  assign st_rd      = move;
  assign pc_push    = move && posted_q;
  assign np_push    = move && !posted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_COLLECT;
      active_q <= 1'b0;
      posted_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_COLLECT: begin
          if (st_wr) active_q <= !in_eot_i;
          if (st_wr && in_eot_i) begin
            posted_q <= in_posted_i;
            state_q  <= ST_CHECK;
          end
        end
        ST_CHECK: state_q <= crc_err_i ? ST_COLLECT : ST_DRAIN;
        ST_DRAIN: if (move && st_count == SCW'(1)) state_q <= ST_COLLECT;
        default:  state_q <= ST_COLLECT;
      endcase
    end
  end

  stage_buf #(.DEPTH(STAGE_DEPTH)) i_stage (
    .clk_i, .rst_ni,
    .wr_en_i  (st_wr),
    .wr_data_i(in_data_i),
    .rewind_i (st_rewind),
    .rd_en_i  (st_rd),
    .rd_data_o(st_data),
    .empty_o  (st_empty),
    .full_o   (st_full),
    .count_o  (st_count)
  );

  byte_fifo #(.DEPTH(PC_DEPTH)) i_pc_q (
    .clk_i, .rst_ni,
    .push_i (pc_push),
    .data_i (st_data),
    .pop_i  (pc_pop_i),
    .data_o (pc_data_o),
    .empty_o(pc_empty_o),
    .full_o (pc_full),
    .level_o(pc_level)
  );

  byte_fifo #(.DEPTH(NP_DEPTH)) i_np_q (
    .clk_i, .rst_ni,
    .push_i (np_push),
    .data_i (st_data),
    .pop_i  (np_pop_i),
    .data_o (np_data_o),
    .empty_o(np_empty_o),
    .full_o (np_full),
    .level_o(np_level)
  );

  // free flags sized for a worst-case transaction of each class
  assign pc_free_o = (PLW'(PC_DEPTH) - pc_level) >= PLW'(PC_NEED);
  assign np_free_o = (NLW'(NP_DEPTH) - np_level) >= NLW'(NP_NEED);

  a_r5_ready_low_after_eot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && in_eot_i) |=> !in_ready_o);
  a_r4_drop_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_CHECK) && crc_err_i) |=> (!pc_push && !np_push && st_empty));
  a_r2_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_push, np_push}));
  a_r6_stall_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_DRAIN) && tgt_full) |=> $stable(st_count));
endmodule

// File: tb/test_crc_stage_buf.sv
`timescale 1ns/1ps
module test_crc_stage_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sot = 1'b0, in_eot = 1'b0, in_posted = 1'b0, crc_err = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       pc_pop = 1'b0, np_pop = 1'b0;
  logic [7:0] pc_data, np_data;
  logic       pc_empty, pc_free, np_empty, np_free;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] exp_pc [$];
  logic [7:0] exp_np [$];

  always #2 clk = ~clk;

  crc_stage_buf i_crc_stage_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sot_i(in_sot),
    .in_eot_i(in_eot), .in_posted_i(in_posted), .crc_err_i(crc_err),
    .in_ready_o(in_ready),
    .pc_pop_i(pc_pop), .pc_data_o(pc_data), .pc_empty_o(pc_empty), .pc_free_o(pc_free),
    .np_pop_i(np_pop), .np_data_o(np_data), .np_empty_o(np_empty), .np_free_o(np_free)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_byte(input logic [7:0] d, input bit sot, input bit eot, input bit posted);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sot = sot; in_eot = eot; in_posted = posted;
    @(negedge clk);
    in_valid = 1'b0; in_sot = 1'b0; in_eot = 1'b0;
  endtask

  // returns at the falling edge right after the end byte is accepted
  task automatic send_txn(input int n, input bit posted, input bit err, input logic [7:0] seed);
    crc_err = err;
    for (int i = 0; i < n; i++) begin
      drive_byte(seed + 8'(i * 3), i == 0, i == n - 1, posted);
      if (!err) begin
        if (posted) exp_pc.push_back(seed + 8'(i * 3));
        else        exp_np.push_back(seed + 8'(i * 3));
      end
    end
  endtask

  task automatic wait_idle(input string req);
    int cnt = 0;
    @(negedge clk);
    while (!in_ready && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    chk(in_ready, req, in_ready, 1);
  endtask

  task automatic pop_check(input bit pc, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      logic [7:0] a;
      logic emp;
      e   = pc ? exp_pc.pop_front() : exp_np.pop_front();
      a   = pc ? pc_data : np_data;
      emp = pc ? pc_empty : np_empty;
      chk(!emp && a == e, req, {emp, a}, e);
      if (pc) pc_pop = 1'b1; else np_pop = 1'b1;
      @(negedge clk);
      pc_pop = 1'b0; np_pop = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(in_ready, "R1 ready", in_ready, 1);
    chk(pc_empty && np_empty, "R1 empty", {pc_empty, np_empty}, 3);
    chk(pc_free && np_free, "R1 free", {pc_free, np_free}, 3);
  endtask

  task automatic t_latency_posted();
    send_txn(5, 1'b1, 1'b0, 8'h10);
    chk(!in_ready, "R5 ready low after eot", in_ready, 0);
    chk(pc_empty, "R5 empty at k", pc_empty, 1);
    @(negedge clk);
    chk(pc_empty, "R5 empty at k+1", pc_empty, 1);
    @(negedge clk);
    chk(!pc_empty && pc_data == 8'h10, "R5 first byte at k+2", pc_data, 8'h10);
    chk(!in_ready, "R5 ready low while copying", in_ready, 0);
    wait_idle("R5 ready returns");
    chk(np_empty, "R2 np untouched", np_empty, 1);
    pop_check(1'b1, 5, "R2 posted order");
    chk(pc_empty, "R2 pc drained", pc_empty, 1);
  endtask

  task automatic t_nonposted();
    send_txn(7, 1'b0, 1'b0, 8'h40);
    wait_idle("R3 idle");
    chk(pc_empty, "R3 pc untouched", pc_empty, 1);
    pop_check(1'b0, 7, "R3 np order");
    chk(np_empty, "R3 np drained", np_empty, 1);
  endtask

  task automatic t_crc_drop();
    send_txn(9, 1'b1, 1'b1, 8'h80);
    wait_idle("R4 idle after drop");
    repeat (3) @(negedge clk);
    chk(pc_empty && np_empty, "R4 nothing delivered", {pc_empty, np_empty}, 3);
    send_txn(3, 1'b0, 1'b0, 8'hA0);
    wait_idle("R4 idle");
    pop_check(1'b0, 3, "R4 next txn intact");
    chk(np_empty && pc_empty, "R4 no leftovers", {pc_empty, np_empty}, 3);
  endtask

  task automatic t_outside_bytes();
    drive_byte(8'hEE, 1'b0, 1'b0, 1'b1);
    drive_byte(8'hED, 1'b0, 1'b0, 1'b1);
    drive_byte(8'hEC, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk(pc_empty && np_empty && in_ready, "R9 stray bytes dropped", {pc_empty, np_empty, in_ready}, 7);
    send_txn(4, 1'b1, 1'b0, 8'h20);
    wait_idle("R9 idle");
    pop_check(1'b1, 4, "R9 only framed bytes");
    chk(pc_empty, "R9 pc drained", pc_empty, 1);
  endtask

  task automatic t_restart();
    drive_byte(8'h55, 1'b1, 1'b0, 1'b0);
    drive_byte(8'h56, 1'b0, 1'b0, 1'b0);
    drive_byte(8'h57, 1'b0, 1'b0, 1'b0);
    send_txn(4, 1'b0, 1'b0, 8'h60);
    wait_idle("R10 idle");
    pop_check(1'b0, 4, "R10 restart keeps new txn");
    chk(np_empty, "R10 partial bytes gone", np_empty, 1);
  endtask

  task automatic t_single();
    send_txn(1, 1'b1, 1'b0, 8'h3C);
    wait_idle("R11 idle");
    pop_check(1'b1, 1, "R11 single byte");
    chk(pc_empty, "R11 pc drained", pc_empty, 1);
  endtask

  task automatic t_pc_free_and_stall();
    send_txn(10, 1'b1, 1'b0, 8'h01);
    wait_idle("R7 idle");
    send_txn(9, 1'b1, 1'b0, 8'h30);
    wait_idle("R7 idle");
    chk(pc_free, "R7 room 13 free", pc_free, 1);
    send_txn(1, 1'b1, 1'b0, 8'h77);
    wait_idle("R7 idle");
    chk(!pc_free, "R7 room 12 not free", pc_free, 0);
    send_txn(14, 1'b1, 1'b0, 8'h90);
    repeat (30) @(negedge clk);
    chk(!in_ready, "R6 stalled while full", in_ready, 0);
    chk(!pc_free && !pc_empty, "R6 queue full", {pc_free, pc_empty}, 0);
    pop_check(1'b1, 34, "R6 no loss after stall");
    wait_idle("R6 resumes");
    chk(pc_empty && pc_free, "R6 drained", {pc_empty, pc_free}, 3);
  endtask

  task automatic t_np_free();
    send_txn(11, 1'b0, 1'b0, 8'hC0);
    wait_idle("R8 idle");
    chk(np_free, "R8 room 5 free", np_free, 1);
    send_txn(1, 1'b0, 1'b0, 8'hD0);
    wait_idle("R8 idle");
    chk(!np_free, "R8 room 4 not free", np_free, 0);
    pop_check(1'b0, 12, "R8 contents");
    chk(np_free && np_empty, "R8 free again", {np_free, np_empty}, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency_posted();
    t_nonposted();
    t_crc_drop();
    t_outside_bytes();
    t_restart();
    t_single();
    t_pc_free_and_stall();
    t_np_free();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule